// File: doc/BRIEF.md
# LCD Frame Interrupt Controller

This block sits beside the timing generator of a multiplexed segment LCD. It raises two interrupts. The shutdown interrupt fires when the module-active flag falls. The frame interrupt fires at a programmable point before a frame boundary, once the controller has read all the pixel data it needs. It also decides whether a CPU write to the pixel data registers may go through. With Type-B waveforms and more than one common, the panel needs identical data in both frames of an even/odd pair, or a DC component appears. In that mode a write is accepted only inside a window that opens with the frame interrupt. A write outside the window is dropped and sets a sticky error flag.

The timing generator supplies a tick strobe, the number of ticks left before the next frame boundary (the boundary is the leading edge of the first common phase), and a bit marking the odd frame of a pair. The block needs nothing else about the panel's timing. It does not store pixel data. It only emits a write-enable level and a write-accepted strobe.

Top module: `lcd_frame_irq_ctrl`

## Requirements
- R1: When `active_i` goes from 1 to 0, `shut_irq_o` is 1 from the following clock edge.
- R2: The design is in protected mode when `active_i`=1, `type_b_i`=1 (1 selects Type-B, 0 selects Type-A) and `mux_sel_i`≠00 (00 is static drive). In protected mode, a cycle with `tick_i`=1, `frame_odd_i`=1 and `ticks_left_i`=TFINT sets `frame_irq_o` at the next edge. This happens once per even/odd frame pair.
- R3: No frame interrupt is produced with Type-A, with static drive, or while inactive.
- R4: The write window opens in the cycle of the frame interrupt event. It stays open in every following cycle until TFWR further ticks have been counted. Cycles without a tick do not age it.
- R5: In protected mode, a write request outside the window gives no `wr_ack_o` and sets `wr_err_o` at the next edge. A request inside the window gives `wr_ack_o`=1 in the same cycle.
- R6: Outside protected mode (Type-A, static, or inactive), every write request is acknowledged and `wr_err_o` is never set.
- R7: `frame_irq_o`, `shut_irq_o` and `wr_err_o` each stay set until their own clear input is 1. A set and a clear in the same cycle leave the flag at 1.
- R8: After reset all three flags are 0 and `wr_en_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| active_i | input | 1 | LCD module active |
| type_b_i | input | 1 | waveform select, 1 = Type-B |
| mux_sel_i | input | 2 | multiplex select, 00 = static |
| tick_i | input | 1 | timing-generator tick strobe |
| ticks_left_i | input | CNT_W | ticks left until next frame boundary |
| frame_odd_i | input | 1 | current frame is the odd one of a pair |
| wr_req_i | input | 1 | CPU pixel write attempt |
| clr_frame_i | input | 1 | clear frame interrupt flag |
| clr_shut_i | input | 1 | clear shutdown interrupt flag |
| clr_err_i | input | 1 | clear write-error flag |
| frame_irq_o | output | 1 | sticky frame interrupt flag |
| shut_irq_o | output | 1 | sticky shutdown interrupt flag |
| wr_err_o | output | 1 | sticky write-error flag |
| wr_en_o | output | 1 | pixel writes currently permitted |
| wr_ack_o | output | 1 | this cycle's write is accepted |

## Verification
The sweep covers all eight waveform and multiplex combinations across two full frame pairs, with a tick every cycle. It checks three things: that the interrupt lands only on the odd frame's TFINT point, that an interrupt on every frame or in Type-A is caught, and that rejected writes set the error flag. The window is longer than TFINT, so it runs across the frame boundary. A window one tick short or one tick long is caught by the accept/reject decision on each cycle. A separate test stalls the ticks inside the window, to catch a window that times out on clock cycles instead of ticks. Further tests check set-beats-clear on the sticky flags and writes while inactive, which must never raise an error.

// File: rtl/lcdfi_pkg.sv
package lcdfi_pkg;
  typedef enum logic {WAVE_A = 1'b0, WAVE_B = 1'b1} wave_e;
  localparam logic [1:0] MUX_STATIC = 2'b00;
  localparam int unsigned N_FLAGS = 3;
  localparam int unsigned F_FRAME = 0;
  localparam int unsigned F_SHUT  = 1;
  localparam int unsigned F_ERR   = 2;
endpackage

// File: rtl/lcdfi_frame_tap.sv
module lcdfi_frame_tap
  import lcdfi_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned TFINT = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             type_b_i,
  input  logic [1:0]       mux_sel_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] ticks_left_i,
  input  logic             frame_odd_i,
  output logic             protect_o,
  output logic             pulse_o,
  output logic             shut_o
);
  logic active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) active_q <= 1'b0;
    else         active_q <= active_i;
  end

  assign shut_o    = active_q & ~active_i;
  assign protect_o = active_i & (wave_e'(type_b_i) == WAVE_B) & (mux_sel_i != MUX_STATIC);
  // pair completes at end of odd frame
  assign pulse_o   = protect_o & tick_i & frame_odd_i & (ticks_left_i == CNT_W'(TFINT));

  a_r1_fall_detect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !active_i) |-> shut_o);
endmodule

// File: rtl/lcdfi_wr_gate.sv
module lcdfi_wr_gate #(
  parameter int unsigned TFWR = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic protect_i,
  input  logic open_i,
  input  logic tick_i,
  input  logic wr_req_i,
  output logic wr_en_o,
  output logic wr_ack_o,
  output logic wr_rej_o
);
  localparam int unsigned WIN_W = $clog2(TFWR + 1);
  logic [WIN_W-1:0] win_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      win_q <= '0;
    else if (open_i)                  win_q <= WIN_W'(TFWR);
    else if (tick_i && win_q != '0)   win_q <= win_q - 1'b1;
  end

  assign wr_en_o  = ~protect_i | open_i | (win_q != '0);
  assign wr_ack_o = wr_req_i & wr_en_o;
  assign wr_rej_o = wr_req_i & ~wr_en_o;

  a_r4_win_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_q <= WIN_W'(TFWR));
  a_r4_win_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !open_i) |=> (win_q == $past(win_q)));
  a_r6_unprotected_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !protect_i |-> wr_en_o);
endmodule

// File: rtl/lcdfi_flag.sv
module lcdfi_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);
  a_r7_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);
endmodule

// File: rtl/lcd_frame_irq_ctrl.sv
module lcd_frame_irq_ctrl
  import lcdfi_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned TFINT = 4,
  parameter int unsigned TFWR  = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             type_b_i,
  input  logic [1:0]       mux_sel_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] ticks_left_i,
  input  logic             frame_odd_i,
  input  logic             wr_req_i,
  input  logic             clr_frame_i,
  input  logic             clr_shut_i,
  input  logic             clr_err_i,
  output logic             frame_irq_o,
  output logic             shut_irq_o,
  output logic             wr_err_o,
  output logic             wr_en_o,
  output logic             wr_ack_o
);
  logic protect, pulse, shut, wr_rej;
  logic [N_FLAGS-1:0] set_v, clr_v, flag_v;

  lcdfi_frame_tap #(.CNT_W(CNT_W), .TFINT(TFINT)) u_tap (
    .clk_i, .rst_ni, .active_i, .type_b_i, .mux_sel_i, .tick_i,
    .ticks_left_i, .frame_odd_i,
    .protect_o(protect), .pulse_o(pulse), .shut_o(shut)
  );

  lcdfi_wr_gate #(.TFWR(TFWR)) u_gate (
    .clk_i, .rst_ni, .protect_i(protect), .open_i(pulse), .tick_i,
    .wr_req_i, .wr_en_o, .wr_ack_o, .wr_rej_o(wr_rej)
  );

  assign set_v[F_FRAME] = pulse;
  assign set_v[F_SHUT]  = shut;
  assign set_v[F_ERR]   = wr_rej;
  assign clr_v[F_FRAME] = clr_frame_i;
  assign clr_v[F_SHUT]  = clr_shut_i;
  assign clr_v[F_ERR]   = clr_err_i;

  for (genvar i = 0; i < N_FLAGS; i++) begin : g_flag
    lcdfi_flag u_flag (
      .clk_i, .rst_ni, .set_i(set_v[i]), .clr_i(clr_v[i]), .flag_o(flag_v[i])
    );
  end

  assign frame_irq_o = flag_v[F_FRAME];
  assign shut_irq_o  = flag_v[F_SHUT];
  assign wr_err_o    = flag_v[F_ERR];

  a_r1_shutdown: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_i) |=> shut_irq_o);
  a_r3_no_frame_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_irq_o) |-> $past(active_i && type_b_i && (mux_sel_i != MUX_STATIC)));
  a_r5_reject_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_i && !wr_en_o) |=> wr_err_o);
  a_r5_ack_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ack_o |-> wr_en_o);
endmodule

// File: tb/lcd_frame_irq_ctrl_tb.sv
`timescale 1ns/1ps
module lcd_frame_irq_ctrl_tb;
  localparam int CNT_W = 8;
  localparam int TFINT = 4;
  localparam int TFWR  = 6;
  localparam int FL    = 16;

  logic clk = 0, rst_ni = 0;
  logic active, type_b, tick, odd, wr_req, clr_f, clr_s, clr_e;
  logic [1:0] mux;
  logic [CNT_W-1:0] left;
  logic frame_irq, shut_irq, wr_err, wr_en, wr_ack;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  lcd_frame_irq_ctrl #(.CNT_W(CNT_W), .TFINT(TFINT), .TFWR(TFWR)) u_dut (
    .clk_i(clk), .rst_ni, .active_i(active), .type_b_i(type_b), .mux_sel_i(mux),
    .tick_i(tick), .ticks_left_i(left), .frame_odd_i(odd), .wr_req_i(wr_req),
    .clr_frame_i(clr_f), .clr_shut_i(clr_s), .clr_err_i(clr_e),
    .frame_irq_o(frame_irq), .shut_irq_o(shut_irq), .wr_err_o(wr_err),
    .wr_en_o(wr_en), .wr_ack_o(wr_ack)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_ni = 0; active = 0; type_b = 0; mux = 0; tick = 0; odd = 0;
    left = '0; wr_req = 0; clr_f = 1; clr_s = 1; clr_e = 1;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_ni = 1;
  endtask

  // one cycle: drive at negedge, check comb ack, then flags after edge
  task automatic cyc(input string req, input logic exp_ack, input logic exp_fi,
                     input logic exp_err);
    #1 chk({req, " ack"}, wr_ack, exp_ack);
    @(posedge clk); #1;
    chk({req, " frame_irq"}, frame_irq, exp_fi);
    chk({req, " wr_err"}, wr_err, exp_err);
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R8 reset state
    #1;
    chk("R8 frame", frame_irq, 0); chk("R8 shut", shut_irq, 0);
    chk("R8 err", wr_err, 0);      chk("R8 wr_en", wr_en, 1);

    // R2 R3 R4 R5 R6: sweep of all waveform/mux configs, tick every cycle
    for (int cfg = 0; cfg < 8; cfg++) begin
      do_reset();
      type_b = cfg[2]; mux = cfg[1:0]; active = 1;
      for (int t = 0; t < 4 * FL; t++) begin
        automatic int pos = t % FL;
        automatic int q0 = 2 * FL - TFINT;
        automatic bit prot = type_b && (mux != 0);
        automatic bit pls = prot && ((t / FL) % 2 == 1) && (pos == FL - TFINT);
        automatic bit ok = !prot ||
             (t >= q0 && (((t % (2 * FL)) - q0 + 2 * FL) % (2 * FL)) <= TFWR);
        tick = 1; left = CNT_W'(FL - pos); odd = ((t / FL) % 2) == 1; wr_req = 1;
        cyc(prot ? "R2/R4/R5" : "R3/R6", ok, pls, !ok);
      end
    end

    // R1 shutdown and R6 inactive writes, R7 sticky shut flag
    do_reset();
    type_b = 1; mux = 2'b11; active = 1; clr_s = 0; clr_e = 0;
    @(posedge clk); @(negedge clk);
    active = 0; wr_req = 1; tick = 1; odd = 1; left = CNT_W'(TFINT);
    #1 chk("R6 inactive ack", wr_ack, 1);
    @(posedge clk); #1;
    chk("R1 shut_irq", shut_irq, 1);
    chk("R3 inactive no frame", frame_irq, 0);
    chk("R6 inactive no err", wr_err, 0);
    @(negedge clk); tick = 0;
    repeat (3) @(posedge clk); #1;
    chk("R7 shut sticky", shut_irq, 1);
    @(negedge clk); clr_s = 1;
    @(posedge clk); #1 chk("R7 shut cleared", shut_irq, 0);

    // R7 frame flag sticky, set beats clear; R4 window ages on ticks only
    do_reset();
    type_b = 1; mux = 2'b01; active = 1; clr_f = 0; clr_e = 0; wr_req = 1;
    tick = 1; odd = 1; left = CNT_W'(TFINT);
    cyc("R4 open cycle", 1, 1, 0);
    tick = 0; odd = 0;
    for (int k = 0; k < 20; k++) cyc("R4 no-tick hold", 1, 1, 0);
    tick = 1;
    for (int k = 0; k < TFWR; k++) cyc("R4 tick ageing", 1, 1, 0);
    cyc("R5 window closed", 0, 1, 1);
    tick = 0;
    cyc("R7 err sticky", 0, 1, 1);
    wr_req = 0; clr_e = 1; clr_f = 1;
    cyc("R7 cleared", 0, 0, 0);
    // same-cycle set and clear of frame flag
    tick = 1; odd = 1; left = CNT_W'(TFINT); clr_f = 1;
    cyc("R7 set beats clear", 0, 1, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule